// File: doc/BRIEF.md
# Mode-Banked UART Control Register Front End

This block holds the control and status registers of a 16550-style serial port with extended features. A narrow synchronous register bus (word address, write enable, read enable, 16-bit write data, combinational read data) reaches a different physical register at the same address depending on which bank is open. The bank follows from the value last written to the line control register. A second layer of gating depends on an extended-functions enable bit and a modem control submode bit. These decide whether the upper interrupt enable bits and the trigger-level register can be reached.

The serial shifters, FIFOs and baud generator are outside the block. It exports the committed 16-bit baud divisor (for a 16x-oversampled clock from a 48 MHz reference), a port enable, the FIFO enable and the interrupt enable byte. It takes receive-data-available and transmit-FIFO-empty status as inputs. Received bytes arrive on `rx_data` while `rx_avail` is high. A bus read of the holding register pops one byte with `rx_pop`, and a read with `rx_avail` low pops nothing. Transmit bytes leave as a one-cycle `tx_valid` strobe with `tx_data`. There is no back-pressure on that strobe, so the bus master must see the transmit-empty status bit set before it writes a byte.

A soft reset is started through a control word and completes after a fixed number of cycles. While it runs, all bus writes are dropped.

Top module: `uart_bank_regs`

## Requirements
- R1: The bank is chosen from the line control value (offset 3, reachable in every bank). 0xBF opens config bank B. Any other value with bit 7 set opens config bank A. A value with bit 7 clear opens the operating bank.
- R2: The extended feature register sits at offset 2 in config bank B only, and its bit 4 is the extended-functions enable. In the other banks, offset 2 does not reach this register.
- R3: Interrupt enable (offset 1, operating bank) bits [3:0] are always writable. Bits [7:4] change only while extended-functions enable is 1, and otherwise keep their value. `irq_en` shows all 8 bits.
- R4: When extended-functions enable and modem control (offset 4, operating bank and config bank A) bit 6 are both 1, offset 7 reaches the 8-bit trigger-level register. When either bit is 0, offset 7 reads 0 and writes to it are dropped.
- R5: FIFO control is at offset 2 in the operating bank and in config bank A. It is write-only and reads 0. Its bit 0 drives `fifo_en`.
- R6: In both config banks, offsets 0 and 1 reach the divisor low and high bytes. In the operating bank they reach the holding register and interrupt enable.
- R7: Mode definition is at offset 8 in every bank, with bits [2:0]. `uart_en` is 1 only while the field is 0, and 7 disables the port. The bytes {high, low} are copied to `baud_div` only when a write moves the field from non-zero to 0.
- R8: Writing offset 21 with bit 1 set starts a soft reset. Bit 1 of offset 21 reads 1 while the reset runs and then clears itself. Bit 0 of offset 22 drops at the request and reads 1 again 4 cycles after the request edge. The request returns line control, extended feature, modem control, interrupt enable, FIFO enable, trigger level, divisor bytes and `baud_div` to 0, and mode definition to 7. Writes during the reset are dropped.
- R9: Line status is at offset 5 and is readable in the operating bank only. Bit 0 equals `rx_avail`, bit 5 equals `tx_fifo_empty`, and the other bits read 0.
- R10: In the operating bank, a write to offset 0 raises `tx_valid` for exactly the following cycle, with `tx_data` equal to write data [7:0]. A read of offset 0 returns `rx_data` and asserts `rx_pop` in the same cycle when `rx_avail` is 1.
- R11: A read of a register that cannot be reached in the current bank returns 0, and a write to it changes no state. Modem control cannot be reached in config bank B.
- R12: After hardware reset, line control reads 0, mode definition reads 7, offset 22 bit 0 reads 1, and `baud_div`, `uart_en`, `fifo_en`, `irq_en` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register word offset |
| bus_wr | input | 1 | Write enable, sampled at the clock edge |
| bus_rd | input | 1 | Read enable (qualifies `rx_pop` only) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| rx_data | input | 8 | Receive byte at the head of the receive FIFO |
| rx_avail | input | 1 | Receive data available |
| rx_pop | output | 1 | Receive byte consumed this cycle |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| baud_div | output | 16 | Committed baud divisor |
| uart_en | output | 1 | Port enabled in 16x mode |
| fifo_en | output | 1 | FIFO enable |
| irq_en | output | 8 | Interrupt enable byte |

## Verification
The properties assume that the bus drives `bus_wr` and `bus_addr` as clean values at every clock edge after reset. They also assume that `tx_valid` is only ever explained by a holding-register write made in the operating bank. The bench keeps to this by changing bus signals only on the falling clock edge and releasing `bus_wr` after one cycle. It opens each bank by writing line control before it touches the banked offsets. The divisor and soft-reset properties also assume the reset counter starts only from a write to the control word, and the bench issues that write only while no reset is running.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

  typedef enum logic [1:0] {
    BANK_OPER = 2'd0,
    BANK_CFGA = 2'd1,
    BANK_CFGB = 2'd2
  } bank_e;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_HOLD,
    SEL_DLO,
    SEL_DHI,
    SEL_IEN,
    SEL_XFEAT,
    SEL_LCTL,
    SEL_MCTL,
    SEL_FCTL,
    SEL_LSTAT,
    SEL_TRIG,
    SEL_MDEF,
    SEL_SRCTL,
    SEL_SRSTAT
  } reg_sel_e;

  localparam int OFS_HOLD  = 0;
  localparam int OFS_IEN   = 1;
  localparam int OFS_FCX   = 2;
  localparam int OFS_LCTL  = 3;
  localparam int OFS_MCTL  = 4;
  localparam int OFS_LSTAT = 5;
  localparam int OFS_TRIG  = 7;
  localparam int OFS_MDEF  = 8;
  localparam int OFS_SRCTL = 21;
  localparam int OFS_SRSTA = 22;

  localparam logic [7:0] LCTL_CFGB_KEY = 8'hBF;
  localparam int XFEAT_EN_BIT = 4;
  localparam int MCTL_SUB_BIT = 6;
  localparam int SRCTL_GO_BIT = 1;

  function automatic bank_e bank_of(input logic [7:0] lctl);
    if (lctl == LCTL_CFGB_KEY) return BANK_CFGB;
    else if (lctl[7])          return BANK_CFGA;
    else                       return BANK_OPER;
  endfunction

endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        lctl,
  input  logic              submode,
  output reg_sel_e          sel
);

  bank_e bank;

  always_comb begin
    bank = bank_of(lctl);
    sel  = SEL_NONE;
    case (addr)
      ADDR_W'(OFS_HOLD):  sel = (bank == BANK_OPER) ? SEL_HOLD  : SEL_DLO;
      ADDR_W'(OFS_IEN):   sel = (bank == BANK_OPER) ? SEL_IEN   : SEL_DHI;
      ADDR_W'(OFS_FCX):   sel = (bank == BANK_CFGB) ? SEL_XFEAT : SEL_FCTL;
      ADDR_W'(OFS_LCTL):  sel = SEL_LCTL;
      ADDR_W'(OFS_MCTL):  sel = (bank == BANK_CFGB) ? SEL_NONE  : SEL_MCTL;
      ADDR_W'(OFS_LSTAT): sel = (bank == BANK_OPER) ? SEL_LSTAT : SEL_NONE;
      ADDR_W'(OFS_TRIG):  sel = submode ? SEL_TRIG : SEL_NONE;
      ADDR_W'(OFS_MDEF):  sel = SEL_MDEF;
      ADDR_W'(OFS_SRCTL): sel = SEL_SRCTL;
      ADDR_W'(OFS_SRSTA): sel = SEL_SRSTAT;
      default:            sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/uart_bank_srst.sv
module uart_bank_srst #(
  parameter int RST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(RST_CYC) + 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b1;
      cnt_q <= '0;
    end else if (kick) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == CNT_W'(RST_CYC - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [7:0]        rx_data,
  input  logic              rx_avail,
  output logic              rx_pop,
  input  logic              tx_fifo_empty,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic [15:0]       baud_div,
  output logic              uart_en,
  output logic              fifo_en,
  output logic [7:0]        irq_en
);

  localparam int BYTE_W = 8;
  localparam int MDEF_W = 3;
  localparam logic [MDEF_W-1:0] MDEF_OFF  = '1;
  localparam logic [MDEF_W-1:0] MDEF_RUN  = '0;
  localparam int LSTAT_RX = 0;
  localparam int LSTAT_TX = 5;

  reg_sel_e sel;
  logic     submode, sr_busy, sr_done, wr_ok, kick;

  logic [BYTE_W-1:0]   lctl_q, xfeat_q, mctl_q, ien_q, trig_q, dlo_q, dhi_q;
  logic [MDEF_W-1:0]   mdef_q;
  logic                fen_q;
  logic [2*BYTE_W-1:0] div_q;
  logic                txv_q;
  logic [BYTE_W-1:0]   txd_q;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:BYTE_W];

  assign submode = xfeat_q[XFEAT_EN_BIT] & mctl_q[MCTL_SUB_BIT];
  assign wr_ok   = bus_wr & ~sr_busy;
  assign kick    = wr_ok & (sel == SEL_SRCTL) & bus_wdata[SRCTL_GO_BIT];

  uart_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .lctl    (lctl_q),
    .submode (submode),
    .sel     (sel)
  );

  uart_bank_srst #(.RST_CYC(RST_CYC)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (kick),
    .busy  (sr_busy),
    .done  (sr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lctl_q  <= '0;
      xfeat_q <= '0;
      mctl_q  <= '0;
      ien_q   <= '0;
      trig_q  <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      mdef_q  <= MDEF_OFF;
      fen_q   <= 1'b0;
      div_q   <= '0;
      txv_q   <= 1'b0;
      txd_q   <= '0;
    end else begin
      txv_q <= 1'b0;
      if (kick) begin
        lctl_q  <= '0;
        xfeat_q <= '0;
        mctl_q  <= '0;
        ien_q   <= '0;
        trig_q  <= '0;
        dlo_q   <= '0;
        dhi_q   <= '0;
        mdef_q  <= MDEF_OFF;
        fen_q   <= 1'b0;
        div_q   <= '0;
      end else if (wr_ok) begin
        case (sel)
          SEL_HOLD: begin
            txv_q <= 1'b1;
            txd_q <= bus_wdata[BYTE_W-1:0];
          end
          SEL_DLO:   dlo_q   <= bus_wdata[BYTE_W-1:0];
          SEL_DHI:   dhi_q   <= bus_wdata[BYTE_W-1:0];
          SEL_IEN: begin
            ien_q[3:0] <= bus_wdata[3:0];
            if (xfeat_q[XFEAT_EN_BIT]) ien_q[7:4] <= bus_wdata[7:4];
          end
          SEL_XFEAT: xfeat_q <= bus_wdata[BYTE_W-1:0];
          SEL_LCTL:  lctl_q  <= bus_wdata[BYTE_W-1:0];
          SEL_MCTL:  mctl_q  <= bus_wdata[BYTE_W-1:0];
          SEL_FCTL:  fen_q   <= bus_wdata[0];
          SEL_TRIG:  trig_q  <= bus_wdata[BYTE_W-1:0];
          SEL_MDEF: begin
            if (bus_wdata[MDEF_W-1:0] == MDEF_RUN && mdef_q != MDEF_RUN)
              div_q <= {dhi_q, dlo_q};
            mdef_q <= bus_wdata[MDEF_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_HOLD:   bus_rdata = DATA_W'(rx_data);
      SEL_DLO:    bus_rdata = DATA_W'(dlo_q);
      SEL_DHI:    bus_rdata = DATA_W'(dhi_q);
      SEL_IEN:    bus_rdata = DATA_W'(ien_q);
      SEL_XFEAT:  bus_rdata = DATA_W'(xfeat_q);
      SEL_LCTL:   bus_rdata = DATA_W'(lctl_q);
      SEL_MCTL:   bus_rdata = DATA_W'(mctl_q);
      SEL_TRIG:   bus_rdata = DATA_W'(trig_q);
      SEL_MDEF:   bus_rdata = DATA_W'(mdef_q);
      SEL_LSTAT: begin
        bus_rdata[LSTAT_RX] = rx_avail;
        bus_rdata[LSTAT_TX] = tx_fifo_empty;
      end
      SEL_SRCTL:  bus_rdata[SRCTL_GO_BIT] = sr_busy;
      SEL_SRSTAT: bus_rdata[0] = sr_done;
      default:    bus_rdata = '0;
    endcase
  end

  assign rx_pop   = bus_rd & (sel == SEL_HOLD) & rx_avail;
  assign tx_valid = txv_q;
  assign tx_data  = txd_q;
  assign baud_div = div_q;
  assign uart_en  = (mdef_q == MDEF_RUN);
  assign fifo_en  = fen_q;
  assign irq_en   = ien_q;

endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk #(
  parameter int ADDR_W  = 5,
  parameter int RST_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [15:0]       bus_rdata,
  input logic [7:0]        lctl_q,
  input logic [7:0]        xfeat_q,
  input logic [7:0]        ien_q,
  input logic              kick,
  input logic              sr_done,
  input logic              tx_valid,
  input logic              uart_en,
  input logic              fifo_en,
  input logic [15:0]       baud_div
);

  logic [15:0] since_kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_kick <= '1;
    else if (kick)               since_kick <= '0;
    else if (since_kick != '1)   since_kick <= since_kick + 1'b1;
  end

  // R10: a transmit strobe follows a holding-register write
  a_r10_tx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(bus_wr) && $past(bus_addr) == ADDR_W'(0)));

  // R7: a running port never sees its divisor move
  a_r7_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_en && $past(uart_en)) |-> $stable(baud_div));

  // R8: completion appears a fixed number of cycles after the request
  a_r8_done_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_done) |-> (since_kick == 16'(RST_CYC)));

  // R3: upper interrupt enables hold while extended functions are off
  a_r3_ien_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(xfeat_q[4]) && !$past(kick)) |-> $stable(ien_q[7:4]));

  // R5: the FIFO enable moves only on a write or a soft reset
  a_r5_fifo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bus_wr) && !$past(kick)) |-> $stable(fifo_en));

  // R11: modem control is hidden in config bank B
  a_r11_mctl_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (lctl_q == 8'hBF && bus_addr == ADDR_W'(4)) |-> (bus_rdata == 16'h0000));

endmodule

bind uart_bank_regs uart_bank_regs_chk #(.ADDR_W(ADDR_W), .RST_CYC(RST_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .lctl_q    (lctl_q),
  .xfeat_q   (xfeat_q),
  .ien_q     (ien_q),
  .kick      (kick),
  .sr_done   (sr_done),
  .tx_valid  (tx_valid),
  .uart_en   (uart_en),
  .fifo_en   (fifo_en),
  .baud_div  (baud_div)
);

// File: tb/uart_bank_regs_tb.sv
`timescale 1ns/1ps
module uart_bank_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  rx_data = '0;
  logic        rx_avail = 1'b0;
  logic        rx_pop;
  logic        tx_fifo_empty = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic [15:0] baud_div;
  logic        uart_en, fifo_en;
  logic [7:0]  irq_en;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_bank_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_data(rx_data), .rx_avail(rx_avail),
    .rx_pop(rx_pop), .tx_fifo_empty(tx_fifo_empty), .tx_valid(tx_valid), .tx_data(tx_data),
    .baud_div(baud_div), .uart_en(uart_en), .fifo_en(fifo_en), .irq_en(irq_en)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO-free check FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input int a, output logic [15:0] v, output logic pop);
    bus_addr = 5'(a); bus_rd = 1'b1;
    #1; v = bus_rdata; pop = rx_pop;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rdchk(input string req, input int a, input logic [15:0] exp);
    logic [15:0] v; logic p;
    rd(a, v, p);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    rdchk("R12 lctl", 3, 16'h0000);
    rdchk("R12 mdef", 8, 16'h0007);
    rdchk("R12 srstat", 22, 16'h0001);
    chk("R12 outs", {baud_div}, 16'h0000);
    chk("R12 flags", {12'h0, uart_en, fifo_en, tx_valid, 1'b0}, 16'h0000);
    chk("R12 irq_en", {8'h0, irq_en}, 16'h0000);
  endtask

  task automatic t_banks();
    wr(3, 16'h0080);
    wr(0, 16'h0034);
    wr(1, 16'h0012);
    rdchk("R6 dlo cfgA", 0, 16'h0034);
    rdchk("R6 dhi cfgA", 1, 16'h0012);
    wr(3, 16'h00BF);
    rdchk("R1 cfgB dlo", 0, 16'h0034);
    wr(3, 16'h00C0);
    rdchk("R1 other bit7 value is cfgA", 1, 16'h0012);
    wr(3, 16'h0003);
    rdchk("R1 R6 oper ien", 1, 16'h0000);
    rx_data = 8'h5A; rx_avail = 1'b1;
    rdchk("R6 oper rhr", 0, 16'h005A);
    rx_avail = 1'b0;
  endtask

  task automatic t_xfeat();
    wr(3, 16'h0080);
    wr(2, 16'h0010);
    wr(3, 16'h00BF);
    rdchk("R2 xfeat untouched from cfgA", 2, 16'h0000);
    wr(2, 16'h0010);
    rdchk("R2 xfeat cfgB", 2, 16'h0010);
    wr(3, 16'h0000);
    rdchk("R2 R5 offset2 in oper", 2, 16'h0000);
  endtask

  task automatic t_ien();
    wr(3, 16'h00BF); wr(2, 16'h0000); wr(3, 16'h0000);
    wr(1, 16'h00FF);
    rdchk("R3 upper blocked", 1, 16'h000F);
    wr(3, 16'h00BF); wr(2, 16'h0010); wr(3, 16'h0000);
    wr(1, 16'h00A5);
    rdchk("R3 upper open", 1, 16'h00A5);
    wr(3, 16'h00BF); wr(2, 16'h0000); wr(3, 16'h0000);
    wr(1, 16'h0003);
    rdchk("R3 upper kept", 1, 16'h00A3);
    chk("R3 irq_en", {8'h0, irq_en}, 16'h00A3);
  endtask

  task automatic t_trig();
    wr(3, 16'h0080); wr(4, 16'h0040);
    wr(7, 16'h0099);
    rdchk("R4 trig hidden", 7, 16'h0000);
    wr(3, 16'h00BF); wr(2, 16'h0010); wr(3, 16'h0080);
    rdchk("R4 trig not written earlier", 7, 16'h0000);
    wr(7, 16'h003C);
    rdchk("R4 trig open", 7, 16'h003C);
    wr(4, 16'h0000);
    rdchk("R4 trig closed", 7, 16'h0000);
  endtask

  task automatic t_fifo();
    wr(3, 16'h0000);
    wr(2, 16'h0001);
    chk("R5 fifo_en set", {15'h0, fifo_en}, 16'h0001);
    rdchk("R5 fctl write-only", 2, 16'h0000);
    wr(3, 16'h0080);
    wr(2, 16'h0000);
    chk("R5 fifo_en cleared cfgA", {15'h0, fifo_en}, 16'h0000);
  endtask

  task automatic t_div();
    wr(3, 16'h0080); wr(0, 16'h001A); wr(1, 16'h0000);
    wr(8, 16'h0000);
    chk("R7 commit", baud_div, 16'h001A);
    chk("R7 uart_en", {15'h0, uart_en}, 16'h0001);
    wr(0, 16'h0034);
    chk("R7 no commit while running", baud_div, 16'h001A);
    wr(8, 16'h0000);
    chk("R7 no commit 0->0", baud_div, 16'h001A);
    wr(8, 16'h0007);
    chk("R7 disabled", {15'h0, uart_en}, 16'h0000);
    chk("R7 div kept", baud_div, 16'h001A);
    wr(8, 16'h0000);
    chk("R7 recommit", baud_div, 16'h0034);
  endtask

  task automatic t_lstat();
    wr(3, 16'h0000);
    rx_avail = 1'b1; tx_fifo_empty = 1'b0;
    rdchk("R9 rx bit", 5, 16'h0001);
    rx_avail = 1'b0; tx_fifo_empty = 1'b1;
    rdchk("R9 tx bit", 5, 16'h0020);
    wr(3, 16'h0080);
    rdchk("R9 R11 hidden in cfgA", 5, 16'h0000);
    tx_fifo_empty = 1'b0;
  endtask

  task automatic t_txrx();
    logic [15:0] v; logic p;
    wr(3, 16'h0000);
    wr(0, 16'h0077);
    chk("R10 tx strobe", {7'h0, tx_valid, tx_data}, 16'h0177);
    @(negedge clk); #1;
    chk("R10 tx strobe one cycle", {15'h0, tx_valid}, 16'h0000);
    rx_data = 8'hC3; rx_avail = 1'b1;
    rd(0, v, p);
    chk("R10 rx data", v, 16'h00C3);
    chk("R10 rx pop", {15'h0, p}, 16'h0001);
    rx_avail = 1'b0;
    rd(0, v, p);
    chk("R10 no pop when empty", {15'h0, p}, 16'h0000);
    wr(3, 16'h0080);
    rx_avail = 1'b1;
    rd(0, v, p);
    chk("R10 no pop in cfgA", {15'h0, p}, 16'h0000);
    rx_avail = 1'b0;
    wr(0, 16'h0011);
    chk("R10 no tx in cfgA", {15'h0, tx_valid}, 16'h0000);
  endtask

  task automatic t_hidden();
    wr(3, 16'h0080); wr(4, 16'h0000);
    wr(3, 16'h00BF);
    wr(4, 16'h0055);
    rdchk("R11 mctl read cfgB", 4, 16'h0000);
    wr(3, 16'h0080);
    rdchk("R11 mctl unchanged", 4, 16'h0000);
    rdchk("R11 unmapped offset", 12, 16'h0000);
  endtask

  task automatic t_srst();
    wr(3, 16'h0000); wr(1, 16'h000C); wr(2, 16'h0001); wr(8, 16'h0000);
    wr(21, 16'h0002);
    rdchk("R8 done low", 22, 16'h0000);
    wr(3, 16'h0080);
    rdchk("R8 busy flag", 21, 16'h0002);
    rdchk("R8 done low before 4", 22, 16'h0000);
    rdchk("R8 done at 4", 22, 16'h0001);
    rdchk("R8 request self-clears", 21, 16'h0000);
    rdchk("R8 lctl cleared, write dropped", 3, 16'h0000);
    rdchk("R8 mdef 7", 8, 16'h0007);
    rdchk("R8 ien cleared", 1, 16'h0000);
    chk("R8 outs", {baud_div[14:0], fifo_en}, 16'h0000);
    chk("R8 uart_en", {15'h0, uart_en}, 16'h0000);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_banks();
    t_xfeat();
    t_ien();
    t_trig();
    t_fifo();
    t_div();
    t_lstat();
    t_txrx();
    t_hidden();
    t_srst();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule